// File: doc/BRIEF.md
# Transmit Descriptor Decoder

This block sits between a descriptor fetch unit and a transmit engine. It takes one 128-bit transmit descriptor at a time, made of four 32-bit words. Word 0 is held in bits [31:0] and word 3 in bits [127:96]. Bit 30 of word 3 tells a packet descriptor from a context descriptor. Bit 31 of word 3 is the ownership flag, and 1 means the hardware owns the descriptor. For a packet descriptor the block decodes the segment and offload controls and presents one command to the transmit engine. It then waits for the engine to report completion and produces the status byte to be written back over bits [31:24] of word 3.

A context descriptor does not produce a command. It can load a maximum segment size that later segmented packets use. It is accepted only between packets. If a context descriptor arrives inside a multi-descriptor packet, its contents are dropped and the block flags an error in its write-back. If a descriptor arrives still owned by software, the block parks in a suspended state until the fetch side asks it to resume.

Top module: `tx_desc_engine`

## Requirements
- R1: A descriptor accepted with word3[31]=0 sends the block into suspend. In suspend, `suspended` is 1, `desc_ready` is 0, and neither a command nor a write-back is issued until a one-cycle `resume` pulse returns the block to idle with `desc_ready`=1. After reset the block is idle with `desc_ready`=1 and every output strobe low.
- R2: Every write-back is a one-cycle `wb_valid` pulse with `wb_byte[7]` (ownership) cleared. For a packet descriptor the byte is {0, 0, first, last, error, 3'b000}, where first is word3[29] and last is word3[28].
- R3: The error bit `wb_byte[3]` is set only for a last-segment descriptor whose buffer lengths word2[13:0] and word2[29:16] are both zero.
- R4: A command is marked segmented (`cmd_seg`) only when word3[18], word3[29] and `seg_en` are all 1 and the limits of R5 and R6 hold. Otherwise the packet is treated as unsegmented.
- R5: The header length is word2[9:0]. Its minimum is 48 when source-address insertion is asked for (word3[24:23] nonzero) and 54 otherwise. A shorter header gives an unsegmented command.
- R6: The TCP header length word3[22:19], counted in 32-bit words, must be at least 5 for segmentation.
- R7: A segmented command carries `cmd_len`=word3[17:0], `cmd_hdr_len`=word2[9:0] and `cmd_tcp_hl`=word3[22:19]. An unsegmented one carries `cmd_len`=word3[14:0] with the header and TCP header lengths at zero. The buffer lengths, first and last are always passed through.
- R8: An in-sequence context descriptor with word3[26]=1 and word3[27]=0 loads word2[13:0] into `cmd_mss`. `cmd_mss` resets to 0 and changes at no other time.
- R9: A context descriptor is written back as 8'h40 when in sequence. It is written back as 8'h60 (context error) when it arrives after a non-last packet descriptor and before the matching last one, and in that case it is otherwise ignored.
- R10: `tx_irq` is a one-cycle pulse, given together with the write-back of a last-segment descriptor whose word2[31] is set, and never otherwise.
- R11: `cmd_valid` stays high with all command fields stable until `cmd_ready` is sampled high. The write-back of a packet descriptor appears only in the cycle after a `tx_done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_en | input | 1 | Channel-level permission to segment |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Block idle and able to take a descriptor |
| desc_data | input | 128 | Descriptor words 3..0, with word 3 in the top bits |
| resume | input | 1 | Leave the suspended state |
| suspended | output | 1 | Stopped on a descriptor owned by software |
| cmd_valid | output | 1 | Command to the transmit engine is valid |
| cmd_ready | input | 1 | Transmit engine takes the command |
| cmd_first | output | 1 | First segment of a packet |
| cmd_last | output | 1 | Last segment of a packet |
| cmd_seg | output | 1 | Segmentation granted |
| cmd_buf1_len | output | 14 | Buffer 1 length |
| cmd_buf2_len | output | 14 | Buffer 2 length |
| cmd_hdr_len | output | 10 | Header length (segmented only) |
| cmd_tcp_hl | output | 4 | TCP header length in words (segmented only) |
| cmd_len | output | 18 | Payload length when segmented, frame length otherwise |
| cmd_mss | output | 14 | Latched maximum segment size |
| tx_done | input | 1 | Transmit engine finished the current descriptor |
| wb_valid | output | 1 | Write-back byte valid |
| wb_byte | output | 8 | Value for bits [31:24] of word 3 |
| tx_irq | output | 1 | Completion interrupt pulse |

## Verification
Random packet descriptors vary the first and last flags, the segment request, the source-address mode, the header and TCP header lengths and the zero-length buffers. These show whether the segmentation grant and the length fields are chosen by the right rule, and whether errors land only on closing descriptors. Directed cases put header lengths exactly on and one below each minimum, and set the TCP header length to 4. These separate an off-by-one threshold from a correct one. Context descriptors are sent between packets, inside a packet, and with the timestamp bit set. Together they tell an accepted size from a dropped one and show the error marking. A software-owned descriptor checks that suspend holds until resume.

// File: rtl/tx_desc_engine.sv
module tx_desc_engine #(
  parameter int HDR_MIN_SA    = 48,
  parameter int HDR_MIN_PLAIN = 54,
  parameter int THL_MIN       = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         seg_en,
  input  logic         desc_valid,
  output logic         desc_ready,
  input  logic [127:0] desc_data,
  input  logic         resume,
  output logic         suspended,
  output logic         cmd_valid,
  input  logic         cmd_ready,
  output logic         cmd_first,
  output logic         cmd_last,
  output logic         cmd_seg,
  output logic [13:0]  cmd_buf1_len,
  output logic [13:0]  cmd_buf2_len,
  output logic [9:0]   cmd_hdr_len,
  output logic [3:0]   cmd_tcp_hl,
  output logic [17:0]  cmd_len,
  output logic [13:0]  cmd_mss,
  input  logic         tx_done,
  output logic         wb_valid,
  output logic [7:0]   wb_byte,
  output logic         tx_irq
);

  localparam logic [9:0] HMIN_SA    = 10'(HDR_MIN_SA);
  localparam logic [9:0] HMIN_PLAIN = 10'(HDR_MIN_PLAIN);
  localparam logic [3:0] THL_LOW    = 4'(THL_MIN);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_WAIT, S_WB, S_SUSP} state_t;
  state_t state;

  logic [31:0] w2, w3;
  logic        in_pkt, irq_pend;
  logic        take, is_own, is_ctx, is_fd, is_ld;
  logic        seg_req, hdr_ok, thl_ok, seg_ok, zero_len, mss_load;
  logic [9:0]  hdr_min;

  assign w2       = desc_data[95:64];
  assign w3       = desc_data[127:96];
  assign is_own   = w3[31];
  assign is_ctx   = w3[30];
  assign is_fd    = w3[29];
  assign is_ld    = w3[28];
  assign hdr_min  = (w3[24:23] != 2'b00) ? HMIN_SA : HMIN_PLAIN;
  assign seg_req  = w3[18] && is_fd && seg_en;
  assign hdr_ok   = w2[9:0] >= hdr_min;
  assign thl_ok   = w3[22:19] >= THL_LOW;
  assign seg_ok   = seg_req && hdr_ok && thl_ok;
  assign zero_len = (w2[13:0] == 14'd0) && (w2[29:16] == 14'd0);
  assign mss_load = w3[26] && !w3[27] && !in_pkt;

  assign desc_ready = (state == S_IDLE);
  assign suspended  = (state == S_SUSP);
  assign cmd_valid  = (state == S_CMD);
  assign wb_valid   = (state == S_WB);
  assign tx_irq     = wb_valid && irq_pend;
  assign take       = desc_valid && desc_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      in_pkt       <= 1'b0;
      irq_pend     <= 1'b0;
      cmd_mss      <= '0;
      cmd_first    <= 1'b0;
      cmd_last     <= 1'b0;
      cmd_seg      <= 1'b0;
      cmd_buf1_len <= '0;
      cmd_buf2_len <= '0;
      cmd_hdr_len  <= '0;
      cmd_tcp_hl   <= '0;
      cmd_len      <= '0;
      wb_byte      <= '0;
    end else begin
      case (state)
        S_IDLE: if (take) begin
          if (!is_own) begin
            state <= S_SUSP;
          end else if (is_ctx) begin
            wb_byte  <= {1'b0, 1'b1, in_pkt, 5'b0};
            irq_pend <= 1'b0;
            if (mss_load) cmd_mss <= w2[13:0];
            state    <= S_WB;
          end else begin
            cmd_first    <= is_fd;
            cmd_last     <= is_ld;
            cmd_seg      <= seg_ok;
            cmd_buf1_len <= w2[13:0];
            cmd_buf2_len <= w2[29:16];
            cmd_hdr_len  <= seg_ok ? w2[9:0] : 10'd0;
            cmd_tcp_hl   <= seg_ok ? w3[22:19] : 4'd0;
            cmd_len      <= seg_ok ? w3[17:0] : {3'b0, w3[14:0]};
            wb_byte      <= {2'b00, is_fd, is_ld, is_ld && zero_len, 3'b000};
            irq_pend     <= is_ld && w2[31];
            in_pkt       <= !is_ld;
            state        <= S_CMD;
          end
        end
        S_CMD:  if (cmd_ready) state <= S_WAIT;
        S_WAIT: if (tx_done)   state <= S_WB;
        S_WB:   state <= S_IDLE;
        S_SUSP: if (resume)    state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r2_own_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !wb_byte[7]);
  a_r2_wb_single: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !wb_valid);
  a_r3_err_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_byte[6] && wb_byte[3] |-> wb_byte[4]);
  a_r10_irq_closing: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> wb_valid && wb_byte[4] && !wb_byte[6]);
  a_r11_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable({cmd_len, cmd_hdr_len, cmd_seg, cmd_first, cmd_last}));
  a_r11_wb_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $past(state) == S_WAIT && wb_valid |-> $past(tx_done));
  a_r8_mss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(cmd_mss));
  a_r1_suspend_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    suspended && !resume |=> suspended && !cmd_valid && !wb_valid);

endmodule

// File: tb/tb_tx_desc_engine.sv
module tb_tx_desc_engine;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, seg_en = 0, desc_valid = 0, resume = 0, cmd_ready = 0, tx_done = 0;
  logic [127:0] desc_data = '0;
  logic desc_ready, suspended, cmd_valid, cmd_first, cmd_last, cmd_seg, wb_valid, tx_irq;
  logic [13:0] cmd_buf1_len, cmd_buf2_len, cmd_mss;
  logic [9:0] cmd_hdr_len;
  logic [3:0] cmd_tcp_hl;
  logic [17:0] cmd_len;
  logic [7:0] wb_byte;

  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;
  logic m_inpkt = 0;
  logic [13:0] m_mss = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_desc_engine dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic logic e_seg(input logic [31:0] w2, input logic [31:0] w3, input logic en);
    logic [9:0] mn;
    mn = (w3[24:23] != 2'b00) ? 10'd48 : 10'd54;
    return w3[18] && w3[29] && en && (w2[9:0] >= mn) && (w3[22:19] >= 4'd5);
  endfunction

  function automatic logic [17:0] e_len(input logic [31:0] w3, input logic s);
    return s ? w3[17:0] : {3'b0, w3[14:0]};
  endfunction

  function automatic logic [7:0] e_wb(input logic [31:0] w2, input logic [31:0] w3);
    logic err;
    err = w3[28] && (w2[13:0] == 0) && (w2[29:16] == 0);
    return {2'b00, w3[29], w3[28], err, 3'b000};
  endfunction

  task automatic offer(input logic [31:0] w2, input logic [31:0] w3);
    @(negedge clk);
    desc_data  = {w3, w2, $urandom(), $urandom()};
    desc_valid = 1;
    @(posedge clk);
    @(negedge clk);
    desc_valid = 0;
  endtask

  task automatic run_pkt(input logic [31:0] w2, input logic [31:0] w3, input int hold, input int gap);
    logic s;
    logic [17:0] l0;
    s = e_seg(w2, w3, seg_en);
    offer(w2, w3);
    chk("R11 cmd_valid", cmd_valid, 1);
    chk("R4 cmd_seg", cmd_seg, s);
    chk("R7 cmd_len", cmd_len, e_len(w3, s));
    chk("R7 hdr/thl", {cmd_hdr_len, cmd_tcp_hl}, s ? {w2[9:0], w3[22:19]} : 14'd0);
    chk("R7 bufs/first/last", {cmd_buf1_len, cmd_buf2_len, cmd_first, cmd_last}, {w2[13:0], w2[29:16], w3[29], w3[28]});
    chk("R8 cmd_mss", cmd_mss, m_mss);
    l0 = cmd_len;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R11 hold", {cmd_valid, cmd_len}, {1'b1, l0});
    end
    cmd_ready = 1;
    @(negedge clk);
    cmd_ready = 0;
    for (int i = 0; i < gap; i++) begin
      chk("R11 no early wb", wb_valid, 0);
      @(negedge clk);
    end
    tx_done = 1;
    @(negedge clk);
    tx_done = 0;
    chk("R2 wb_valid", wb_valid, 1);
    chk("R2 R3 wb_byte", wb_byte, e_wb(w2, w3));
    chk("R10 tx_irq", tx_irq, w3[28] && w2[31]);
    m_inpkt = !w3[28];
    @(negedge clk);
    chk("R2 wb single", {wb_valid, tx_irq}, 0);
  endtask

  task automatic run_ctx(input logic [13:0] mss, input logic valid_b, input logic ost_b);
    logic [31:0] w3;
    w3 = 32'hC000_0000 | (32'(valid_b) << 26) | (32'(ost_b) << 27);
    offer({18'h0, mss}, w3);
    chk("R9 ctx wb", {wb_valid, wb_byte}, {1'b1, m_inpkt ? 8'h60 : 8'h40});
    chk("R10 no irq on ctx", tx_irq, 0);
    if (!m_inpkt && valid_b && !ost_b) m_mss = mss;
    @(negedge clk);
    chk("R8 mss after ctx", cmd_mss, m_mss);
  endtask

  function automatic logic [31:0] mk_w3(input logic fd, ld, tse, input logic [1:0] sa, input logic [3:0] thl, input logic [17:0] pl);
    return {1'b1, 1'b0, fd, ld, 3'b000, sa, thl, tse, pl};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset idle", {desc_ready, suspended, cmd_valid, wb_valid, tx_irq}, 5'b10000);
    chk("R8 reset mss", cmd_mss, 0);

    seg_en = 1;
    run_pkt(32'h8000_0030, mk_w3(1, 1, 1, 2'b01, 4'd5, 18'h2_1234), 0, 1);  // R5 SA at 48
    run_pkt(32'h0000_002F, mk_w3(1, 1, 1, 2'b10, 4'd5, 18'h2_1234), 0, 0);  // R5 SA at 47
    run_pkt(32'h0000_0036, mk_w3(1, 1, 1, 2'b00, 4'd6, 18'h3_FFFF), 1, 0);  // R5 plain 54
    run_pkt(32'h0000_0035, mk_w3(1, 1, 1, 2'b00, 4'd6, 18'h3_FFFF), 0, 0);  // R5 plain 53
    run_pkt(32'h0000_0040, mk_w3(1, 1, 1, 2'b00, 4'd4, 18'h0_0100), 0, 0);  // R6 thl 4
    seg_en = 0;
    run_pkt(32'h0000_0040, mk_w3(1, 1, 1, 2'b00, 4'd8, 18'h0_0100), 0, 0);  // R4 channel off
    seg_en = 1;
    run_pkt(32'h8000_0040, mk_w3(0, 1, 1, 2'b00, 4'd8, 18'h0_0100), 0, 0);  // R4 not first
    run_ctx(14'h05DC, 1, 0);                                                // R8 load
    run_ctx(14'h0111, 1, 1);                                                // R8 timestamp set
    run_pkt(32'h8000_0000, mk_w3(1, 0, 0, 2'b00, 4'd0, 18'h0_0040), 2, 2);  // R10 no irq mid
    run_ctx(14'h0222, 1, 0);                                                // R9 out of sequence
    run_pkt(32'h8000_0000, mk_w3(0, 1, 0, 2'b00, 4'd0, 18'h0_0040), 0, 0);  // R3 zero length

    offer(32'h0, 32'h3000_0000);                                            // R1 not owned
    for (int i = 0; i < 3; i++) begin
      chk("R1 suspended", {suspended, desc_ready, cmd_valid, wb_valid}, 4'b1000);
      @(negedge clk);
    end
    resume = 1;
    @(negedge clk);
    resume = 0;
    chk("R1 resumed", {suspended, desc_ready}, 2'b01);

    for (int n = 0; n < 300; n++) begin
      int r;
      r = $urandom_range(0, 9);
      seg_en = ($urandom_range(0, 3) != 0);
      if (r == 0) begin
        run_ctx(14'($urandom()), 1'($urandom()), 1'($urandom()));
      end else begin
        logic [31:0] w2;
        logic [13:0] b1, b2;
        b1 = ($urandom_range(0, 3) == 0) ? 14'd0 : 14'($urandom_range(40, 70));
        b2 = ($urandom_range(0, 2) == 0) ? 14'd0 : 14'($urandom());
        w2 = {1'($urandom()), 1'b0, b2, 2'b00, b1};
        run_pkt(w2, mk_w3(1'($urandom()), 1'($urandom()), 1'($urandom()), 2'($urandom()),
                          4'($urandom_range(3, 9)), 18'($urandom())),
                $urandom_range(0, 2), $urandom_range(0, 2));
      end
    end
    finish_run();
  end
endmodule